// File: doc/BRIEF.md
# Compacting Micro-op Queue Between Decode and Rename

This block is an elastic buffer placed between a wide decode stage and a narrower rename stage. Each cycle decode offers a group of up to `IN_SLOTS` micro-op slots in program order. Each slot carries a keep bit. A slot that decode has thrown away has its keep bit cleared: a no-op, a plain unconditional jump, or the second half of a fused pair. The write side squeezes these holes out, so that only live micro-ops take up queue entries. Rename therefore sees full groups more often than it would if it were tied directly to decode.

The read side always presents the oldest entries, up to `OUT_SLOTS` of them, as a thermometer valid mask. Rename states through a grant count how many it will take. The number actually taken is reported back, and the head moves by exactly that many. A flush (a pipeline flush or a fetch redirect) empties the queue in one cycle. Decode may refill it starting on the following cycle.

Top module: `uop_compact_queue`

## Requirements
- R1: Slot i of a group sits at `in_data[i*DATA_W +: DATA_W]`, with slot 0 the oldest. `in_keep[i]=1` marks a live slot. The live slots are stored in ascending slot order, and discarded slots never occupy an entry or appear on the output.
- R2: When `in_valid && in_ready && !flush` holds at a rising edge, every kept slot of the group (up to `IN_SLOTS`, default 10) is written in that single cycle.
- R3: `in_ready` is 1 exactly when the free entries (`DEPTH` minus occupancy) are at least the number of kept slots. When `in_ready` is 0 nothing of the group is written, and occupancy never exceeds `DEPTH`.
- R4: `out_valid[j]` is 1 for the lowest min(occupancy, `OUT_SLOTS`) lanes only. Lane j of `out_data` holds the j-th oldest stored micro-op.
- R5: `out_count` equals min(`out_grant`, occupancy, `OUT_SLOTS`), or 0 during a flush. Exactly that many oldest entries are removed at the edge. A grant above `OUT_SLOTS` is treated as `OUT_SLOTS`.
- R6: With `flush=1` at an edge, the queue is empty afterwards and any group offered in that cycle is dropped. A group offered in the next cycle is accepted normally.
- R7: After a synchronous reset the queue is empty: `out_valid=0`, `out_count=0`, and `in_ready=1` for any group.
- R8: Program order is preserved across wrap of the circular storage over many fill and drain cycles.
- R9: When the queue is full (`DEPTH` entries, default 32), `in_ready` is 0 for any group with at least one kept slot. A group with no kept slots is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue; wins over enqueue and dequeue |
| in_valid | input | 1 | Decode offers a group |
| in_keep | input | IN_SLOTS | Per-slot live mask, bit 0 oldest |
| in_data | input | IN_SLOTS*DATA_W | Slot payloads, slot i at bits i*DATA_W |
| in_ready | output | 1 | Room for all kept slots of the offered group |
| out_grant | input | $clog2(OUT_SLOTS+1) | Number of micro-ops rename can take this cycle |
| out_valid | output | OUT_SLOTS | Thermometer mask of presented lanes |
| out_data | output | OUT_SLOTS*DATA_W | Oldest entries, lane 0 oldest |
| out_count | output | $clog2(OUT_SLOTS+1) | Number of micro-ops removed at this edge |

## Verification
The checks assume that decode holds `in_keep` stable within a cycle and applies `in_ready` the way the port table describes it. They also assume that rename treats `out_count`, not its own grant, as the number it received. They assume `DEPTH` is a power of two, so that pointer arithmetic wraps naturally. The stimulus drives every input half a cycle away from the sampling edge. It uses grants from 0 up past `OUT_SLOTS` and keep masks from empty to full, with dense and sparse patterns. Occupancy only reaches `DEPTH` through accepted groups, so the bench never needs to force an illegal state.

// File: rtl/uop_cq_pkg.sv
package uop_cq_pkg;
  function automatic int unsigned umin(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/cq_compact.sv
module cq_compact #(
  parameter int N      = 10,
  parameter int DATA_W = 16,
  localparam int KW    = $clog2(N + 1)
) (
  input  logic [N-1:0]        keep,
  input  logic [N*DATA_W-1:0] din,
  output logic [N*DATA_W-1:0] dout,
  output logic [KW-1:0]       n_kept
);
  // Running count of earlier kept slots gives each live slot its packed lane.
  always_comb begin
    int unsigned pos;
    pos  = 0;
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (keep[i]) begin
        dout[pos*DATA_W +: DATA_W] = din[i*DATA_W +: DATA_W];
        pos = pos + 1;
      end
    end
    n_kept = KW'(pos);
  end
endmodule

// File: rtl/cq_store.sv
module cq_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int WR     = 10,
  parameter int RD     = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int KW    = $clog2(WR + 1)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   wr_base,
  input  logic [KW-1:0]      wr_n,
  input  logic [WR*DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_base,
  output logic [RD*DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < WR; k++) begin
        if (k < int'(wr_n))
          mem[wr_base + IDX_W'(k)] <= wr_data[k*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar j = 0; j < RD; j++) begin : g_rd
    assign rd_data[j*DATA_W +: DATA_W] = mem[rd_base + IDX_W'(j)];
  end
endmodule

// File: rtl/uop_compact_queue.sv
module uop_compact_queue
  import uop_cq_pkg::*;
#(
  parameter int IN_SLOTS  = 10,
  parameter int OUT_SLOTS = 8,
  parameter int DEPTH     = 32,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PTR_W    = IDX_W + 1,
  localparam int KW       = $clog2(IN_SLOTS + 1),
  localparam int GW       = $clog2(OUT_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        in_valid,
  input  logic [IN_SLOTS-1:0]         in_keep,
  input  logic [IN_SLOTS*DATA_W-1:0]  in_data,
  output logic                        in_ready,
  input  logic [GW-1:0]               out_grant,
  output logic [OUT_SLOTS-1:0]        out_valid,
  output logic [OUT_SLOTS*DATA_W-1:0] out_data,
  output logic [GW-1:0]               out_count
);
  logic [PTR_W-1:0]           head, tail, occ;
  logic [IN_SLOTS*DATA_W-1:0] packed_data;
  logic [KW-1:0]              kept_n;
  logic [GW-1:0]              avail;
  logic                       enq;

  cq_compact #(.N(IN_SLOTS), .DATA_W(DATA_W)) u_compact (
    .keep   (in_keep),
    .din    (in_data),
    .dout   (packed_data),
    .n_kept (kept_n)
  );

  assign occ      = tail - head;
  assign in_ready = (32'(occ) + 32'(kept_n)) <= 32'(DEPTH);
  assign enq      = in_valid && in_ready && !flush;
  assign avail    = GW'(umin(32'(occ), 32'(OUT_SLOTS)));

  always_comb begin
    out_count = '0;
    if (!flush)
      out_count = GW'(umin(umin(32'(out_grant), 32'(OUT_SLOTS)), 32'(avail)));
  end

  for (genvar j = 0; j < OUT_SLOTS; j++) begin : g_vld
    assign out_valid[j] = (j < int'(avail));
  end

  cq_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .WR(IN_SLOTS), .RD(OUT_SLOTS)
  ) u_store (
    .clk     (clk),
    .we      (enq),
    .wr_base (tail[IDX_W-1:0]),
    .wr_n    (kept_n),
    .wr_data (packed_data),
    .rd_base (head[IDX_W-1:0]),
    .rd_data (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head <= '0;
      tail <= '0;
    end else begin
      head <= head + PTR_W'(out_count);
      if (enq)
        tail <= tail + PTR_W'(kept_n);
    end
  end
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int IN_SLOTS  = 10,
  parameter int OUT_SLOTS = 8,
  parameter int DEPTH     = 32,
  parameter int PTR_W     = 6,
  parameter int GW        = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 flush,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [IN_SLOTS-1:0]  in_keep,
  input logic [GW-1:0]        out_grant,
  input logic [OUT_SLOTS-1:0] out_valid,
  input logic [GW-1:0]        out_count,
  input logic [PTR_W-1:0]     occ
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    32'(occ) <= 32'(DEPTH));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (out_valid == '0));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    (out_count <= out_grant) && ($countones(out_valid) >= int'(out_count)));

  p_valid_thermo_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid & (out_valid + 1'b1)) == '0);

  p_occ_track_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> int'(occ) == int'($past(occ))
      + (($past(in_valid) && $past(in_ready)) ? $countones($past(in_keep)) : 0)
      - int'($past(out_count)));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (32'(occ) == 32'(DEPTH) && in_keep != '0) |-> !in_ready);
endmodule

bind uop_compact_queue cq_checker #(
  .IN_SLOTS(IN_SLOTS), .OUT_SLOTS(OUT_SLOTS), .DEPTH(DEPTH), .PTR_W(PTR_W), .GW(GW)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_keep(in_keep), .out_grant(out_grant), .out_valid(out_valid),
  .out_count(out_count), .occ(occ)
);

// File: tb/uop_compact_queue_tb.sv
module uop_compact_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 10;
  localparam int NO = 8;
  localparam int DP = 32;
  localparam int W  = 16;

  typedef struct packed {
    logic [NI-1:0] keep;
    logic [3:0]    grant;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{10'h3FF, 4'd0}, '{10'h155, 4'd2}, '{10'h000, 4'd3}, '{10'h201, 4'd8},
    '{10'h3FF, 4'd0}, '{10'h3FF, 4'd1}, '{10'h3FF, 4'd15}, '{10'h0F0, 4'd8},
    '{10'h001, 4'd4}, '{10'h3FF, 4'd8}, '{10'h2AA, 4'd8}, '{10'h3FF, 4'd0},
    '{10'h3FF, 4'd0}, '{10'h3FF, 4'd0}, '{10'h3FF, 4'd0}, '{10'h000, 4'd9}
  };

  logic clk = 0, rst = 1, flush = 0, in_valid = 0;
  logic [NI-1:0]   in_keep = '0;
  logic [NI*W-1:0] in_data = '0;
  logic            in_ready;
  logic [3:0]      out_grant = '0;
  logic [NO-1:0]   out_valid;
  logic [NO*W-1:0] out_data;
  logic [3:0]      out_count;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] seq = 16'h0100;
  logic [W-1:0] mq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_compact_queue u_dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_keep(in_keep),
    .in_data(in_data), .in_ready(in_ready), .out_grant(out_grant),
    .out_valid(out_valid), .out_data(out_data), .out_count(out_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check before the rising edge, update model.
  task automatic step(input bit fl, input bit vl, input logic [NI-1:0] kp,
                      input logic [3:0] gr, input string rq);
    int kept, avail, cnt;
    bit rdy;
    flush = fl; in_valid = vl; in_keep = kp; out_grant = gr;
    for (int i = 0; i < NI; i++) in_data[i*W +: W] = seq + W'(i);
    #1;
    kept  = $countones(kp);
    rdy   = (mq.size() + kept) <= DP;
    avail = (mq.size() < NO) ? mq.size() : NO;
    cnt   = fl ? 0 : ((int'(gr) < avail) ? int'(gr) : avail);
    chk(in_ready == rdy, rq, "R3 in_ready", int'(in_ready), int'(rdy));
    chk(int'(out_count) == cnt, rq, "R5 out_count", int'(out_count), cnt);
    chk($countones(out_valid) == avail && (out_valid & (out_valid + 1'b1)) == '0,
        rq, "R4 out_valid", int'(out_valid), avail);
    for (int j = 0; j < avail; j++)
      chk(out_data[j*W +: W] == mq[j], rq, "R1 lane data",
          int'(out_data[j*W +: W]), int'(mq[j]));
    @(posedge clk);
    if (fl) mq.delete();
    else begin
      for (int j = 0; j < cnt; j++) void'(mq.pop_front());
      if (vl && rdy)
        for (int i = 0; i < NI; i++) if (kp[i]) mq.push_back(seq + W'(i));
    end
    seq = seq + W'(NI);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R7: reset state
    in_keep = '1; #1;
    chk(out_valid == '0, "R7", "reset out_valid", int'(out_valid), 0);
    chk(out_count == '0, "R7", "reset out_count", int'(out_count), 0);
    chk(in_ready == 1'b1, "R7", "reset in_ready", int'(in_ready), 1);
    @(negedge clk);

    // R1 R2 R3 R4 R5: vector table
    foreach (VECS[k]) step(0, 1, VECS[k].keep, VECS[k].grant, "R2");

    // drain, then fill one at a time to full (R9)
    for (int k = 0; k < 8; k++) step(0, 0, '0, 4'd8, "R5");
    for (int k = 0; k < 34; k++) step(0, 1, 10'h001, 4'd0, "R9");
    chk(mq.size() == DP, "R9", "model full", mq.size(), DP);
    step(0, 1, 10'h200, 4'd0, "R9");
    step(0, 1, 10'h000, 4'd0, "R9");
    chk(mq.size() == DP, "R9", "empty group no effect", mq.size(), DP);

    // R6: flush with concurrent enqueue, then refill next cycle
    step(1, 1, 10'h3FF, 4'd8, "R6");
    step(0, 1, 10'h3FF, 4'd0, "R6");
    step(0, 1, 10'h00F, 4'd3, "R6");

    // R8: long run across pointer wrap
    for (int k = 0; k < 80; k++)
      step(0, 1, NI'((k * 37 + 5) ^ (k << 3)), 4'(k % 10), "R8");
    for (int k = 0; k < 6; k++) step(0, 0, '0, 4'd8, "R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule